// File: doc/BRIEF.md
# Floating-Point Status Word and Exception Accumulator

This block holds the 32-bit floating-point status word for a floating-point unit. Several control fields in the word are decoded and sent to an external arithmetic datapath: a 2-bit rounding-mode code and a flush-to-zero flag. When an arithmetic operation completes, that datapath reports it with a one-cycle valid pulse and five raw exception flags. The block folds those flags into sticky bits at the top of the status word.

The low five bits of the word are per-exception trap enables. When a newly reported flag has its enable bit set, the block raises a one-cycle trap pulse. That pulse is registered together with the status update it belongs to. Software can overwrite the whole word through a write port, and a write wins over any flag update in the same cycle.

Top module: `fp_status_keeper`

## Requirements
- R1: After reset the status word is zero, the trap output is low, the rounding-mode code is 0 and the flush-to-zero flag is low.
- R2: The rounding-mode output always equals status bits [10:9]. The codes are 0 = nearest-even, 1 = toward zero, 2 = toward plus infinity and 3 = toward minus infinity.
- R3: The flush-to-zero output always equals status bit 5. That one bit covers both denormal inputs and denormal results.
- R4: On a valid operation with at least one raw flag set, the flags are ORed into the status word on the next cycle. Inexact goes to bit 27, underflow to bit 28, overflow to bit 29, divide-by-zero to bit 30 and invalid to bit 31. Bits that are already set stay set, and bits [26:0] do not change.
- R5: A valid operation with no raw flag set leaves the status word unchanged. Raw flags presented while the valid input is low also have no effect.
- R6: A software write loads the whole word on the next cycle. It takes priority over a flag update in the same cycle: that update is dropped and raises no trap.
- R7: The trap output is high for one cycle, the same cycle the merged word appears, when the new flags ANDed with status bits [4:0] are non-zero. Enable bit i guards flag i, with the bit order of R4 (bit 0 inexact … bit 4 invalid).
- R8: Flags from one operation do not carry over to a later one. The trap stays low after an operation with no enabled flag, and it drops in the cycle after a trap unless another trapping operation follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| swWrEn | input | 1 | Software write strobe for the status word |
| swWrData | input | 32 | Value to load into the status word |
| opValid | input | 1 | One-cycle pulse marking a completed operation |
| rawInexact | input | 1 | Raw inexact flag of that operation |
| rawUnderflow | input | 1 | Raw underflow flag |
| rawOverflow | input | 1 | Raw overflow flag |
| rawDivZero | input | 1 | Raw divide-by-zero flag |
| rawInvalid | input | 1 | Raw invalid-operation flag |
| statusWord | output | 32 | Current status word |
| roundMode | output | 2 | Rounding-mode code for the datapath |
| flushZero | output | 1 | Flush-to-zero enable for the datapath |
| trapPulse | output | 1 | One-cycle trap request |

## Verification
The assertions assume that the raw flags are meaningful only in a cycle where opValid is high. They also assume that every input is stable around the rising edge, so the word sampled one cycle later can be compared with the previous word and the previous inputs. The stimulus changes every input only on the falling edge and returns opValid and swWrEn to zero between operations. In one scenario it deliberately holds raw flags high with opValid low, to show that such flags are ignored. Another scenario asserts a write and an operation together to exercise the priority rule.

// File: rtl/fp_status_pkg.sv
package fp_status_pkg;
  localparam int WORD_W  = 32;
  localparam int FLAG_N  = 5;
  localparam int FLAG_LSB = WORD_W - FLAG_N;
  localparam int RM_LSB  = 9;
  localparam int RM_W    = 2;
  localparam int FTZ_BIT = 5;

  typedef struct packed {
    logic loadSw;
    logic mergeFlags;
    logic trapHit;
  } statusStrobes_t;
endpackage

// File: rtl/fp_status_ctrl.sv
module fp_status_ctrl
  import fp_status_pkg::*;
(
  input  logic              swWrEn,
  input  logic              opValid,
  input  logic [FLAG_N-1:0] flagVec,
  input  logic [FLAG_N-1:0] enableBits,
  output statusStrobes_t    strobes
);
  logic anyFlag;
  logic anyEnabled;

  always_comb begin
    anyFlag    = |flagVec;
    anyEnabled = |(flagVec & enableBits);
    strobes.loadSw     = swWrEn;
    strobes.mergeFlags = !swWrEn && opValid && anyFlag;
    strobes.trapHit    = !swWrEn && opValid && anyEnabled;
  end
endmodule

// File: rtl/fp_status_data.sv
module fp_status_data
  import fp_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  statusStrobes_t    strobes,
  input  logic [WORD_W-1:0] swWrData,
  input  logic [FLAG_N-1:0] flagVec,
  output logic [WORD_W-1:0] statusWord,
  output logic [RM_W-1:0]   roundMode,
  output logic              flushZero,
  output logic [FLAG_N-1:0] enableBits,
  output logic              trapPulse
);
  logic [WORD_W-1:0] statusQ;
  logic              trapQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      trapQ   <= 1'b0;
    end else begin
      trapQ <= strobes.trapHit;
      if (strobes.loadSw)
        statusQ <= swWrData;
      else if (strobes.mergeFlags)
        statusQ[FLAG_LSB +: FLAG_N] <= statusQ[FLAG_LSB +: FLAG_N] | flagVec;
    end
  end

  assign statusWord = statusQ;
  assign trapPulse  = trapQ;
  assign roundMode  = statusQ[RM_LSB +: RM_W];
  assign flushZero  = statusQ[FTZ_BIT];
  assign enableBits = statusQ[FLAG_N-1:0];

  // R6: a write lands on the next cycle regardless of a concurrent operation
  a_r6_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadSw |=> statusWord == $past(swWrData));

  // R4: sticky OR into the top bits, low bits untouched
  a_r4_sticky_merge: assert property (@(posedge clk) disable iff (!rstN)
    strobes.mergeFlags |=> (statusWord[WORD_W-1:FLAG_LSB] ==
      ($past(statusWord[WORD_W-1:FLAG_LSB]) | $past(flagVec)))
      && statusWord[FLAG_LSB-1:0] == $past(statusWord[FLAG_LSB-1:0]));

  // R5: without a write or a flagged operation the word holds
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.loadSw && !strobes.mergeFlags) |=> $stable(statusWord));

  // R7: an enabled new flag produces the trap with the update
  a_r7_trap_on_enable: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.mergeFlags && |(flagVec & statusWord[FLAG_N-1:0])) |=> trapPulse);

  // R8: a trap is only ever caused by a merge in the previous cycle
  a_r8_trap_cause: assert property (@(posedge clk) disable iff (!rstN)
    trapPulse |-> $past(strobes.mergeFlags));
endmodule

// File: rtl/fp_status_keeper.sv
module fp_status_keeper
  import fp_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              swWrEn,
  input  logic [WORD_W-1:0] swWrData,
  input  logic              opValid,
  input  logic              rawInexact,
  input  logic              rawUnderflow,
  input  logic              rawOverflow,
  input  logic              rawDivZero,
  input  logic              rawInvalid,
  output logic [WORD_W-1:0] statusWord,
  output logic [RM_W-1:0]   roundMode,
  output logic              flushZero,
  output logic              trapPulse
);
  logic [FLAG_N-1:0] flagVec;
  logic [FLAG_N-1:0] enableBits;
  statusStrobes_t    strobes;

  // bit order is shared by the status field and the enable field
  assign flagVec = {rawInvalid, rawDivZero, rawOverflow, rawUnderflow, rawInexact};

  fp_status_ctrl uCtrl (
    .swWrEn     (swWrEn),
    .opValid    (opValid),
    .flagVec    (flagVec),
    .enableBits (enableBits),
    .strobes    (strobes)
  );

  fp_status_data uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .swWrData   (swWrData),
    .flagVec    (flagVec),
    .statusWord (statusWord),
    .roundMode  (roundMode),
    .flushZero  (flushZero),
    .enableBits (enableBits),
    .trapPulse  (trapPulse)
  );
endmodule

// File: tb/sim_fp_status_keeper.sv
module sim_fp_status_keeper;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        swWrEn = 1'b0;
  logic [31:0] swWrData = '0;
  logic        opValid = 1'b0;
  logic [4:0]  rawFlags = '0;
  logic [31:0] statusWord;
  logic [1:0]  roundMode;
  logic        flushZero;
  logic        trapPulse;
  int          checks = 0;
  int          errors = 0;
  logic [31:0] expWord = '0;

  always #10 clk = ~clk;

  fp_status_keeper u0 (
    .clk(clk), .rstN(rstN), .swWrEn(swWrEn), .swWrData(swWrData),
    .opValid(opValid), .rawInexact(rawFlags[0]), .rawUnderflow(rawFlags[1]),
    .rawOverflow(rawFlags[2]), .rawDivZero(rawFlags[3]), .rawInvalid(rawFlags[4]),
    .statusWord(statusWord), .roundMode(roundMode), .flushZero(flushZero),
    .trapPulse(trapPulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle of stimulus; outputs are checked at the following falling edge
  task automatic cycle(input logic wr, input logic [31:0] wd, input logic v, input logic [4:0] f);
    swWrEn = wr; swWrData = wd; opValid = v; rawFlags = f;
    @(negedge clk);
    swWrEn = 1'b0; opValid = 1'b0; rawFlags = '0;
  endtask

  task automatic tReset();
    chk("R1 word", statusWord, 32'h0);
    chk("R1 trap", {31'b0, trapPulse}, 32'h0);
    chk("R1 round", {30'b0, roundMode}, 32'h0);
    chk("R1 flush", {31'b0, flushZero}, 32'h0);
  endtask

  task automatic tRoundFlush();
    for (int m = 0; m < 4; m++) begin
      cycle(1'b1, 32'(m) << 9, 1'b0, 5'b0);
      chk("R2 round code", {30'b0, roundMode}, 32'(m));
      chk("R6 write", statusWord, 32'(m) << 9);
    end
    cycle(1'b1, 32'h0000_0020, 1'b0, 5'b0);
    chk("R3 flush on", {31'b0, flushZero}, 32'h1);
    chk("R2 round with flush", {30'b0, roundMode}, 32'h0);
    cycle(1'b1, 32'h0000_0600, 1'b0, 5'b0);
    chk("R3 flush off", {31'b0, flushZero}, 32'h0);
  endtask

  task automatic tMerge();
    cycle(1'b1, 32'h0000_0640, 1'b0, 5'b0);
    expWord = 32'h0000_0640;
    for (int b = 0; b < 5; b++) begin
      cycle(1'b0, '0, 1'b1, 5'(1 << b));
      expWord[27 + b] = 1'b1;
      chk("R4 flag position", statusWord, expWord);
      chk("R4 no trap when disabled", {31'b0, trapPulse}, 32'h0);
    end
    cycle(1'b1, 32'h0000_0001, 1'b0, 5'b0);
    cycle(1'b0, '0, 1'b1, 5'b10010);
    chk("R4 two flags", statusWord, 32'h9000_0001);
    cycle(1'b0, '0, 1'b1, 5'b00010);
    chk("R4 sticky", statusWord, 32'h9000_0001);
  endtask

  task automatic tNoEffect();
    cycle(1'b1, 32'h0000_0123, 1'b0, 5'b0);
    cycle(1'b0, '0, 1'b1, 5'b0);
    chk("R5 valid no flags", statusWord, 32'h0000_0123);
    cycle(1'b0, '0, 1'b0, 5'b11111);
    chk("R5 flags without valid", statusWord, 32'h0000_0123);
    chk("R5 no trap without valid", {31'b0, trapPulse}, 32'h0);
  endtask

  task automatic tPriority();
    cycle(1'b1, 32'h0000_001F, 1'b0, 5'b0);
    cycle(1'b1, 32'h0000_0A1F, 1'b1, 5'b11111);
    chk("R6 write over merge", statusWord, 32'h0000_0A1F);
    chk("R6 no trap on write", {31'b0, trapPulse}, 32'h0);
  endtask

  task automatic tTrap();
    cycle(1'b1, 32'h0000_0004, 1'b0, 5'b0);
    cycle(1'b0, '0, 1'b1, 5'b00001);
    chk("R7 unmatched flag", {31'b0, trapPulse}, 32'h0);
    cycle(1'b0, '0, 1'b1, 5'b00100);
    chk("R7 trap pulse", {31'b0, trapPulse}, 32'h1);
    chk("R7 word with trap", statusWord, 32'h2800_0004);
    cycle(1'b0, '0, 1'b0, 5'b0);
    chk("R8 trap drops", {31'b0, trapPulse}, 32'h0);
    cycle(1'b0, '0, 1'b1, 5'b00001);
    chk("R8 no carry over", {31'b0, trapPulse}, 32'h0);
    cycle(1'b1, 32'h0000_0010, 1'b0, 5'b0);
    cycle(1'b0, '0, 1'b1, 5'b10000);
    chk("R7 invalid enable", {31'b0, trapPulse}, 32'h1);
    cycle(1'b0, '0, 1'b1, 5'b10000);
    chk("R8 back to back", {31'b0, trapPulse}, 32'h1);
    cycle(1'b0, '0, 1'b0, 5'b0);
    chk("R8 drops after", {31'b0, trapPulse}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tRoundFlush();
    tMerge();
    tNoEffect();
    tPriority();
    tTrap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule